// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block takes a single asynchronous serial line and turns the characters it carries into bytes held in a small receive queue. The line rests high between characters. A character opens with a low start bit, carries its data bits with the least significant bit first, may carry one parity bit, and closes with one or two high stop bits. The receiver aligns its timing to the falling edge that opens a character. It then samples each bit at the middle of its bit time, counted in pulses of an externally supplied base-clock enable.

The base-clock enable runs at either sixteen or eight times the bit rate, and a configuration input selects which. The configuration inputs also set the data length (seven or eight bits), whether a parity bit is present, even or odd parity, and the number of stop bits. Complete characters go into a sixteen-entry queue. A consumer reads the queue through a one-cycle registered read port while later characters are still arriving.

Three sticky flags report faults: a low first stop bit, a parity mismatch, and a character that arrived while the queue was full. A single clear input resets all three flags.

Top module: `serial_char_rx`

## Requirements
- R1: While the synchronised line stays high, no character is produced. A character starts only when a base-clock pulse sees the line low after the previous pulse saw it high.
- R2: Data bits are taken least significant bit first. With an 8-bit length (`cfg_len7`=0), all eight received bits appear on `rd_data[7:0]` with the first received bit in bit 0.
- R3: With `cfg_len7`=1, seven data bits are received, they appear in `rd_data[6:0]`, and `rd_data[7]` reads 0.
- R4: With `cfg_par_en`=1, one parity bit follows the data. For even parity (`cfg_par_odd`=0) the data bits plus the parity bit must hold an even number of ones; for odd parity (`cfg_par_odd`=1) the number must be odd. A mismatch sets `err_parity`. With `cfg_par_en`=0, no parity bit is expected and `err_parity` is not set.
- R5: If the first stop bit is sampled low, `err_frame` is set and the character is still stored. With `cfg_two_stop`=1, the receiver waits out a second stop bit before it looks for the next start bit.
- R6: With `cfg_os8`=0, one bit lasts 16 base-clock pulses and is sampled on the 8th pulse after its start. With `cfg_os8`=1, one bit lasts 8 pulses and is sampled on the 4th pulse.
- R7: If the start bit reads high at its midpoint sample, the receiver returns to idle and stores nothing.
- R8: The queue holds up to 16 characters and returns them in arrival order. `fifo_empty` is 1 after reset and whenever the queue is empty. A read strobe `rd_en` on a non-empty queue presents the oldest character on `rd_data` one clock later.
- R9: A character that completes while the queue holds 16 entries is discarded and sets `err_overrun`. The flag stays set until it is cleared, and the stored characters are unchanged.
- R10: `err_clr` clears all three error flags on the next clock. A fault that occurs in the same cycle as the clear takes priority and sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Base-clock enable, one pulse per oversampling period |
| rx_line | input | 1 | Asynchronous serial input, high when idle |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 enables a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_os8 | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| rd_en | input | 1 | Read strobe for the receive queue |
| rd_data | output | 8 | Oldest character, valid one clock after a read |
| fifo_empty | output | 1 | Receive queue holds no characters |
| err_frame | output | 1 | Sticky: a first stop bit was sampled low |
| err_parity | output | 1 | Sticky: a parity mismatch was seen |
| err_overrun | output | 1 | Sticky: a character was lost to a full queue |
| err_clr | input | 1 | Clears all three error flags |

## Verification
The overrun path is the hardest to reach from the ports. The stimulus has to fill all sixteen entries with complete frames and send no read strobe, then deliver a seventeenth frame. At that point the test confirms that the flag has risen and that draining the queue still returns the first sixteen values in order. The glitch case is also hard to reach: the line must fall and rise again before the start bit's midpoint sample. The stimulus holds the line low for only a few base-clock pulses and then confirms that the queue stays empty.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic two_stop;
    logic os8;
  } rx_cfg_t;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_FULL = 16,
  parameter int OS_ALT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  rx_cfg_t           cfg,
  output logic              char_valid,
  output logic [DATA_W-1:0] char_data,
  output logic              char_ferr,
  output logic              char_perr
);
  localparam int CNT_W = $clog2(OS_FULL + 1);
  localparam int IDX_W = $clog2(DATA_W);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  target;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic              perr_q;
  logic              prev_line;
  logic              hit;

  always_comb begin
    period   = cfg.os8 ? CNT_W'(OS_ALT) : CNT_W'(OS_FULL);
    target   = (state == ST_START) ? (period >> 1) : period;
    hit      = tick && ((cnt + 1'b1) == target);
    last_idx = cfg.len7 ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      par_acc    <= 1'b0;
      perr_q     <= 1'b0;
      prev_line  <= 1'b1;
      char_valid <= 1'b0;
      char_data  <= '0;
      char_ferr  <= 1'b0;
      char_perr  <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      if (tick) prev_line <= line;
      if (tick && state != ST_IDLE) cnt <= hit ? '0 : cnt + 1'b1;

      case (state)
        ST_IDLE: begin
          if (tick && prev_line && !line) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (hit) begin
            if (line) begin
              state <= ST_IDLE;
            end else begin
              state   <= ST_DATA;
              bit_idx <= '0;
              par_acc <= 1'b0;
              perr_q  <= 1'b0;
            end
          end
        end
        ST_DATA: begin
          if (hit) begin
            shreg   <= {line, shreg[DATA_W-1:1]};
            par_acc <= par_acc ^ line;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == last_idx)
              state <= cfg.par_en ? ST_PARITY : ST_STOP1;
          end
        end
        ST_PARITY: begin
          if (hit) begin
            perr_q <= ((par_acc ^ line) != cfg.par_odd);
            state  <= ST_STOP1;
          end
        end
        ST_STOP1: begin
          if (hit) begin
            char_valid <= 1'b1;
            char_ferr  <= !line;
            char_perr  <= cfg.par_en && perr_q;
            char_data  <= cfg.len7 ? {1'b0, shreg[DATA_W-1:1]} : shreg;
            state      <= cfg.two_stop ? ST_STOP2 : ST_IDLE;
          end
        end
        ST_STOP2: begin
          if (hit) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_ptr;
  logic [AW:0]       rd_ptr;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en && !empty) rd_data <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en && !full)  wr_ptr <= wr_ptr + 1'b1;
      if (rd_en && !empty) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import serial_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 16,
  parameter int OS_FULL     = 16,
  parameter int OS_ALT      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  input  logic              rx_line,
  input  logic              cfg_len7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_os8,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              fifo_empty,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun,
  input  logic              err_clr
);
  rx_cfg_t           cfg;
  logic              line_s;
  logic              char_valid;
  logic [DATA_W-1:0] char_data;
  logic              char_ferr;
  logic              char_perr;
  logic              fifo_full;

  assign cfg = '{len7: cfg_len7, par_en: cfg_par_en, par_odd: cfg_par_odd,
                 two_stop: cfg_two_stop, os8: cfg_os8};

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_line), .dout(line_s)
  );

  rx_frame #(.DATA_W(DATA_W), .OS_FULL(OS_FULL), .OS_ALT(OS_ALT)) u_frame (
    .clk(clk), .rst(rst), .tick(base_tick), .line(line_s), .cfg(cfg),
    .char_valid(char_valid), .char_data(char_data),
    .char_ferr(char_ferr), .char_perr(char_perr)
  );

  rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(char_valid && !fifo_full), .wr_data(char_data),
    .rd_en(rd_en), .rd_data(rd_data), .empty(fifo_empty), .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      err_frame   <= (char_valid && char_ferr) || (err_frame && !err_clr);
      err_parity  <= (char_valid && char_perr) || (err_parity && !err_clr);
      err_overrun <= (char_valid && fifo_full) || (err_overrun && !err_clr);
    end
  end
endmodule

// File: rtl/serial_char_rx_chk.sv
module serial_char_rx_chk (
  input logic clk,
  input logic rst,
  input logic char_valid,
  input logic fifo_full,
  input logic fifo_empty,
  input logic rd_en,
  input logic err_frame,
  input logic err_parity,
  input logic err_overrun,
  input logic err_clr
);
  a_r8_empty_after_reset: assert property (@(posedge clk) rst |=> fifo_empty);

  a_r8_not_full_and_empty: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  a_r9_overrun_sets: assert property (@(posedge clk) disable iff (rst)
    (char_valid && fifo_full) |=> err_overrun);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_overrun && !err_clr) |=> err_overrun);

  a_r9_full_holds_without_read: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !rd_en) |=> fifo_full);

  a_r10_clear_all: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !char_valid) |=> (!err_frame && !err_parity && !err_overrun));
endmodule

bind serial_char_rx serial_char_rx_chk u_chk (
  .clk(clk), .rst(rst), .char_valid(char_valid), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .rd_en(rd_en), .err_frame(err_frame),
  .err_parity(err_parity), .err_overrun(err_overrun), .err_clr(err_clr)
);

// File: tb/serial_char_rx_bench.sv
`timescale 1ns/1ps
module serial_char_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0, cfg_os8 = 1'b0;
  logic       rd_en = 1'b0, err_clr = 1'b0;
  logic [7:0] rd_data;
  logic       fifo_empty, err_frame, err_parity, err_overrun;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    base_tick = ~base_tick;
  end

  serial_char_rx u_serial_char_rx (
    .clk(clk), .rst(rst), .base_tick(base_tick), .rx_line(rx_line),
    .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_os8(cfg_os8), .rd_en(rd_en),
    .rd_data(rd_data), .fifo_empty(fifo_empty), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun), .err_clr(err_clr)
  );

  // [15] os8 [14] len7 [13] par_en [12] par_odd [11] two_stop
  // [10] bad stop bit [9] wrong parity bit [7:0] data
  localparam logic [15:0] VEC [8] = '{
    16'h00A5, 16'hA03C, 16'h3881, 16'hC8D5,
    16'h626E, 16'h040F, 16'hBAF0, 16'hF42B
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    repeat ((cfg_os8 ? 8 : 16) * 2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_stop, input bit bad_par);
    int n;
    logic p;
    n = cfg_len7 ? 7 : 8;
    send_bit(1'b1);
    send_bit(1'b0);
    p = cfg_par_odd ^ bad_par;
    for (int i = 0; i < n; i++) begin
      send_bit(d[i]);
      p ^= d[i];
    end
    if (cfg_par_en) send_bit(p);
    send_bit(!bad_stop);
    if (cfg_two_stop) send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic read_one(output logic [7:0] v);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic clear_flags();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, exp_d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state, R10 flags clear
    check(fifo_empty == 1'b1, "R8 reset empty", fifo_empty, 1);
    check({err_frame, err_parity, err_overrun} == 3'b000, "R10 reset flags",
          {err_frame, err_parity, err_overrun}, 0);
    // R1 idle line produces nothing
    repeat (200) @(negedge clk);
    check(fifo_empty == 1'b1, "R1 idle no char", fifo_empty, 1);

    for (int k = 0; k < 8; k++) begin
      cfg_os8 = VEC[k][15]; cfg_len7 = VEC[k][14]; cfg_par_en = VEC[k][13];
      cfg_par_odd = VEC[k][12]; cfg_two_stop = VEC[k][11];
      send_frame(VEC[k][7:0], VEC[k][10], VEC[k][9]);
      exp_d = cfg_len7 ? {1'b0, VEC[k][6:0]} : VEC[k][7:0];
      check(fifo_empty == 1'b0, "R8 char stored (R5 even on bad stop)", fifo_empty, 0);
      read_one(v);
      check(v == exp_d, cfg_len7 ? "R3 seven-bit data" : "R2 R6 eight-bit data", v, exp_d);
      check(err_frame == VEC[k][10], "R5 framing flag", err_frame, VEC[k][10]);
      check(err_parity == (VEC[k][13] & VEC[k][9]), "R4 parity flag", err_parity,
            VEC[k][13] & VEC[k][9]);
      check(fifo_empty == 1'b1, "R8 empty after read", fifo_empty, 1);
      clear_flags();
      check({err_frame, err_parity} == 2'b00, "R10 clear", {err_frame, err_parity}, 0);
    end

    // R7 glitch: low for 3 base pulses only
    cfg_os8 = 1'b0; cfg_len7 = 1'b0; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    rx_line = 1'b0;
    repeat (6) @(negedge clk);
    rx_line = 1'b1;
    repeat (32 * 12) @(negedge clk);
    check(fifo_empty == 1'b1, "R7 glitch rejected", fifo_empty, 1);
    check(err_frame == 1'b0, "R7 glitch no flag", err_frame, 0);

    // R9 overrun: 16 stored, 17th dropped
    for (int i = 0; i < 16; i++) send_frame(8'(i + 8'h40), 1'b0, 1'b0);
    check(err_overrun == 1'b0, "R9 no overrun at 16", err_overrun, 0);
    send_frame(8'hEE, 1'b0, 1'b0);
    check(err_overrun == 1'b1, "R9 overrun on 17th", err_overrun, 1);
    for (int i = 0; i < 16; i++) begin
      read_one(v);
      check(v == 8'(i + 8'h40), "R9 R8 order kept", v, i + 8'h40);
    end
    check(fifo_empty == 1'b1, "R9 17th discarded", fifo_empty, 1);
    check(err_overrun == 1'b1, "R9 sticky", err_overrun, 1);
    clear_flags();
    check(err_overrun == 1'b0, "R10 overrun cleared", err_overrun, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule